// File: doc/BRIEF.md
# Cascaded Reseeding Keystream Generator

This block emits a pseudo-random keystream one bit per enabled clock. Internally one 7-bit XOR-feedback shift register is reused for three consecutive stages. After a start pulse the register is loaded with all ones. Once a chosen window of its own output bits has been collected, the next stage reloads the register with that window as a new seed. The third stage then runs freely.

The stream is continuous across the stage boundaries, so a consumer sees one unbroken bit sequence. A consumer reads `key_o` on every cycle that `key_valid_o` is high. `stage_o` reports which stage produced the current bit. A cipher can XOR the stream with data on both the encrypt side and the decrypt side.

Top module: `keystream_cascade`

## Requirements
- R1: After reset `key_valid_o` and `key_o` are 0 and `stage_o` is 0. No bit is produced until a start pulse, whatever `en_i` does.
- R2: A start pulse seeds stage 0 with seven ones, so the first seven valid bits after a start are all 1.
- R3: Within a stage, valid bit n (counted from 1) for n > 7 equals bit n-7 XOR bit n-6 of the same stage. This is the x^7+x^6+1 recurrence.
- R4: Stage 1 is seeded with bits 8 to 14 of stage 0. Its first seven bits repeat those bits in order.
- R5: Stage 2 is seeded with bits 15 to 21 of stage 1. Its first seven bits repeat those bits in order.
- R6: `stage_o` (0, 1, 2) moves from 0 to 1 right after the 14th valid bit of stage 0, and from 1 to 2 right after the 21st valid bit of stage 1. It changes at no other time except on a start pulse. No cycle is lost at a hand-off.
- R7: Stage 2 runs freely with the same recurrence, and `stage_o` stays 2 until reset or start.
- R8: While `en_i` is low, `key_valid_o` and `key_o` are 0 and all state holds. When `en_i` returns high, the sequence resumes at the next bit.
- R9: A start pulse restarts from stage 0 at any time. The cycle with `start_i` high produces no valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Restart from stage 0 with the all-ones seed |
| en_i | input | 1 | Advance one bit this cycle |
| key_o | output | 1 | Keystream bit, 0 when not valid |
| key_valid_o | output | 1 | Key bit valid this cycle |
| stage_o | output | 2 | Index of the stage producing the current bit |

## Verification
The two hand-offs are the hardest points to reach with a strong check. A seed window is only visible as the output of the following stage, and an off-by-one in the window or the load cycle only shows up many bits later. The stimulus drives long enabled runs through bits 14 and 35 of the stream. It also drops `en_i` in single cycles around the boundaries, and it issues restarts inside stage 2. Each bit is compared with a recurrence model that builds the three stages from their seed windows.

// File: rtl/keygen_pkg.sv
package keygen_pkg;
  localparam int unsigned DEF_W      = 7;
  localparam int unsigned DEF_STAGES = 3;

  // last output bit (1-based) of the seed window taken from stage s
  function automatic int unsigned win_last(int unsigned s, int unsigned w);
    return (s + 2) * w;
  endfunction
endpackage

// File: rtl/keygen_lfsr.sv
module keygen_lfsr #(
  parameter int unsigned W     = 7,
  parameter int unsigned TAP_A = 6,
  parameter int unsigned TAP_B = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         shift_i,
  output logic         bit_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= '1;
    else if (load_i)  state_q <= seed_i;
    else if (shift_i) state_q <= {state_q[W-2:0], state_q[TAP_A] ^ state_q[TAP_B]};
  end

  assign bit_o = state_q[W-1];
endmodule

// File: rtl/keygen_window.sv
module keygen_window #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] next_o
);
  logic [W-2:0] win_q;

  // oldest bit ends in the MSB, so it is the first bit the reseeded stage emits
  assign next_o = {win_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      win_q <= '0;
    else if (shift_i) win_q <= next_o[W-2:0];
  end
endmodule

// File: rtl/keygen_seq.sv
module keygen_seq #(
  parameter int unsigned W        = 7,
  parameter int unsigned N_STAGES = 3,
  parameter int unsigned STG_W    = 2,
  parameter int unsigned CNT_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  output logic             fire_o,
  output logic             handoff_o,
  output logic [STG_W-1:0] stage_o
);
  logic             active_q;
  logic [STG_W-1:0] stage_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_stage;
  logic [CNT_W-1:0] end_cnt;

  assign last_stage = (stage_q == STG_W'(N_STAGES - 1));
  assign end_cnt    = CNT_W'(keygen_pkg::win_last(32'(stage_q), W) - 1);
  assign fire_o     = active_q & en_i & ~start_i;
  assign handoff_o  = fire_o & ~last_stage & (cnt_q == end_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      stage_q  <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      stage_q  <= '0;
      cnt_q    <= '0;
    end else if (handoff_o) begin
      stage_q  <= stage_q + 1'b1;
      cnt_q    <= '0;
    end else if (fire_o && !last_stage) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/keystream_cascade.sv
module keystream_cascade #(
  parameter int unsigned W        = keygen_pkg::DEF_W,
  parameter int unsigned N_STAGES = keygen_pkg::DEF_STAGES,
  parameter int unsigned TAP_A    = W - 1,
  parameter int unsigned TAP_B    = W - 2,
  parameter logic [W-1:0] SEED0   = '1,
  localparam int unsigned STG_W   = (N_STAGES > 1) ? $clog2(N_STAGES) : 1,
  localparam int unsigned CNT_W   = $clog2(N_STAGES * W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  output logic             key_o,
  output logic             key_valid_o,
  output logic [STG_W-1:0] stage_o
);
  logic         fire;
  logic         handoff;
  logic         lfsr_bit;
  logic [W-1:0] win_next;
  logic [W-1:0] seed;

  keygen_seq #(.W(W), .N_STAGES(N_STAGES), .STG_W(STG_W), .CNT_W(CNT_W)) i_seq (
    .clk_i, .rst_ni, .start_i, .en_i,
    .fire_o(fire), .handoff_o(handoff), .stage_o(stage_o)
  );

  keygen_window #(.W(W)) i_win (
    .clk_i, .rst_ni, .shift_i(fire), .bit_i(lfsr_bit), .next_o(win_next)
  );

  assign seed = start_i ? SEED0 : win_next;

  keygen_lfsr #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) i_lfsr (
    .clk_i, .rst_ni, .load_i(start_i | handoff), .seed_i(seed),
    .shift_i(fire), .bit_o(lfsr_bit)
  );

  assign key_valid_o = fire;
  assign key_o       = fire & lfsr_bit;
endmodule

// File: rtl/keystream_cascade_chk.sv
module keystream_cascade_chk #(
  parameter int unsigned N_STAGES = 3,
  parameter int unsigned STG_W    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             en_i,
  input logic             key_o,
  input logic             key_valid_o,
  input logic [STG_W-1:0] stage_o
);
  AST_NO_VALID_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !key_valid_o); // R8
  AST_KEY_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_o |-> !key_o); // R8
  AST_HOLD_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !start_i) |=> $stable(stage_o)); // R8
  AST_START_NO_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !key_valid_o); // R9
  AST_START_STAGE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (stage_o == '0)); // R9
  AST_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o <= STG_W'(N_STAGES - 1)); // R6
  AST_STAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stage_o) |-> (($past(start_i) && stage_o == '0) ||
                           ($past(key_valid_o) && stage_o == STG_W'($past(stage_o) + 1'b1)))); // R6
  AST_LAST_STAGE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o == STG_W'(N_STAGES - 1) && !start_i) |=> (stage_o == STG_W'(N_STAGES - 1))); // R7
endmodule

bind keystream_cascade keystream_cascade_chk #(.N_STAGES(N_STAGES), .STG_W(STG_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .en_i(en_i),
  .key_o(key_o), .key_valid_o(key_valid_o), .stage_o(stage_o)
);

// File: tb/test_keystream_cascade.sv
module test_keystream_cascade;
  localparam int PER  = 10;
  localparam int NEXP = 512;
  localparam int NVEC = 16;

  // {start, en, cycles}
  localparam logic [9:0] VEC [0:NVEC-1] = '{
    {1'b0, 1'b1, 8'd5},   {1'b1, 1'b1, 8'd1},   {1'b0, 1'b1, 8'd9},
    {1'b0, 1'b0, 8'd3},   {1'b0, 1'b1, 8'd4},   {1'b0, 1'b0, 8'd1},
    {1'b0, 1'b1, 8'd1},   {1'b0, 1'b0, 8'd2},   {1'b0, 1'b1, 8'd20},
    {1'b0, 1'b0, 8'd1},   {1'b0, 1'b1, 8'd30},  {1'b1, 1'b0, 8'd1},
    {1'b0, 1'b1, 8'd40},  {1'b1, 1'b1, 8'd1},   {1'b0, 1'b1, 8'd200},
    {1'b0, 1'b1, 8'd150}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic en = 1'b0;
  logic key, key_valid;
  logic [1:0] stage;

  int n_chk = 0;
  int n_bad = 0;
  int idx = 0;
  bit started = 1'b0;
  bit exp_arr [0:NEXP-1];

  always #(PER/2) clk = ~clk;

  keystream_cascade i_keystream_cascade (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .en_i(en),
    .key_o(key), .key_valid_o(key_valid), .stage_o(stage)
  );

  function automatic string tag_for(bit st, bit e, int i);
    if (!started)  return "R1";
    if (st)        return "R9";
    if (!e)        return "R8";
    if (i < 7)     return "R2";
    if (i < 14)    return "R3";
    if (i < 35)    return "R4";
    if (i < 42)    return "R5";
    return "R7";
  endfunction

  task automatic compare(bit st, bit e);
    bit ev, ek;
    logic [1:0] es;
    ev = started && e && !st;
    ek = ev ? exp_arr[idx] : 1'b0;
    es = !started ? 2'd0 : (idx < 14) ? 2'd0 : (idx < 35) ? 2'd1 : 2'd2;
    n_chk++;
    if (key_valid !== ev || key !== ek) begin
      n_bad++;
      $display("FAIL %s bit %0d: valid/key = %b/%b expected %b/%b",
               tag_for(st, e, idx), idx, key_valid, key, ev, ek);
    end else if (stage !== es) begin
      n_bad++;
      $display("FAIL R6 bit %0d: stage = %0d expected %0d", idx, stage, es);
    end
  endtask

  task automatic step(bit st, bit e);
    @(negedge clk);
    start = st;
    en = e;
    #1;
    compare(st, e);
    if (st) begin
      idx = 0;
      started = 1'b1;
    end else if (e && started) begin
      idx++;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    bit o0 [1:14];
    bit o1 [1:21];
    bit o2 [1:NEXP];
    for (int n = 1; n <= 7; n++) o0[n] = 1'b1;                 // R2
    for (int n = 8; n <= 14; n++) o0[n] = o0[n-7] ^ o0[n-6];   // R3
    for (int n = 1; n <= 7; n++) o1[n] = o0[n+7];              // R4
    for (int n = 8; n <= 21; n++) o1[n] = o1[n-7] ^ o1[n-6];
    for (int n = 1; n <= 7; n++) o2[n] = o1[n+14];             // R5
    for (int n = 8; n <= NEXP; n++) o2[n] = o2[n-7] ^ o2[n-6]; // R7
    for (int i = 0; i < NEXP; i++)
      exp_arr[i] = (i < 14) ? o0[i+1] : (i < 35) ? o1[i-13] : o2[i-34];

    // R1: reset state
    #2;
    compare(1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NVEC; v++)
      for (int k = 0; k < int'(VEC[v][7:0]); k++)
        step(VEC[v][9], VEC[v][8]);

    // R1: asynchronous reset in the middle of stage 2
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b1;
    started = 1'b0;
    idx = 0;
    #1;
    compare(1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b1);

    // R9, R2, R6: restart with a single-cycle enable gap at each hand-off
    step(1'b1, 1'b1);
    repeat (14) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    repeat (21) step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    repeat (10) step(1'b0, 1'b1);

    finish_run();
  end

  initial begin
    #(PER * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end
endmodule